// File: doc/BRIEF.md
# Addressed Serial Register Bridge

This block is a serial master that carries addressed byte transfers to one peripheral over a clocked link made of four wires: an active-low select, a clock that rests high, an outgoing data line and an incoming data line. Each transfer is framed the way a two-wire register bus frames it: a leading byte holds a 7-bit device address and a direction bit. The link itself has no start condition, no stop condition and no acknowledge bit. The whole burst is bracketed by one select assertion.

A host asks for a write or a read of a given number of payload bytes. For a write, the block pulls each payload byte from the host through a ready/valid handshake just before that byte goes out. For a read, the block hands each assembled byte to the host with a one-cycle strobe. The host programs the bit timing as a half-period given in system clock cycles. A small combinational lookup tells the host whether a given address has a device behind it.

Top module: `adr_serial_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `cs_n` is 1 and `sclk` is 1. `busy`, `wr_ready` and `rd_valid` are 0 after reset.
- R2: The first byte of every transfer is `{req_addr, req_read}`. Bit 0 is 1 for a read and 0 for a write. Every byte leaves most significant bit first.
- R3: `cs_n` falls while `sclk` is high. The first falling edge of `sclk` comes exactly one half-period later.
- R4: Each bit is a low phase of one half-period followed by a high phase of one half-period. `mosi` changes only in the cycle where `sclk` falls, and it holds its value while `sclk` is high.
- R5: During read payload bytes `mosi` stays 0. `miso` is taken in the last cycle of each low phase, after a synchroniser of SYNC_STAGES flops, so a half-period must exceed SYNC_STAGES for reads. After every eighth bit, `rd_valid` pulses for one cycle, with the byte (first bit received as bit 7) on `rd_data`.
- R6: Before each write payload byte, `wr_ready` is raised with `sclk` high and `cs_n` low. The byte is taken in the cycle where `wr_valid` is also high, and `sclk` stays high for as long as the host waits.
- R7: All bytes of one request go out under a single `cs_n` assertion. `cs_n` rises, with `sclk` high, right after the high phase of the final bit. In that same cycle `done` pulses for one cycle and `busy` falls.
- R8: `busy` is high from the cycle after an accepted request until `cs_n` rises. A request raised while `busy` is high is ignored: it starts no transfer and causes no further select assertion.
- R9: `probe_found` is 1 only when `probe_addr` equals 7'h10, and 0 for every other address.
- R10: The half-period is `half_cycles` clock cycles, latched when the request is accepted. A value of 0 acts as 1.
- R11: A request with `req_len` of 0 sends only the address byte and then releases `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_cycles | input | HP_W | Half-period of the serial clock, in clock cycles |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_read | input | 1 | 1 for read, 0 for write |
| req_addr | input | 7 | Device address |
| req_len | input | LEN_W | Number of payload bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| wr_data | input | 8 | Write payload byte from host |
| wr_valid | input | 1 | Host has a write byte available |
| wr_ready | output | 1 | Block wants the next write byte |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| probe_addr | input | 7 | Address to probe |
| probe_found | output | 1 | A device answers at `probe_addr` |
| cs_n | output | 1 | Active-low select |
| sclk | output | 1 | Serial clock, rests high |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
The bound checker watches several line rules on every cycle: the resting levels while idle, the clock being high whenever select changes, data changing only on a falling clock, the fetch handshake only happening with the clock parked high, and the single-cycle shape of the strobes. The exact phase lengths, the byte contents on the wire, and the read bytes rebuilt from the device model can only be shown by the bench's transfers. The same goes for the ignored busy-time requests, the zero-length burst and the clamped half-period, which the bench measures against a device model at the pins.

// File: rtl/asm_pkg.sv
package asm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SEL   = 3'd1,
      ST_FETCH = 3'd2,
      ST_LOW   = 3'd3,
      ST_HIGH  = 3'd4
   } asm_state_e;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned BIT_IDX_W = 3;

   function automatic logic [BYTE_W-1:0] head_byte(input logic [6:0] addr, input logic rd);
      return {addr, rd};
   endfunction

endpackage

// File: rtl/asm_phase_timer.sv
module asm_phase_timer #(
   parameter int unsigned HP_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic [HP_W-1:0] reload,
   output logic            expired
);

   logic [HP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= reload - HP_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - HP_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/asm_in_sync.sv
module asm_in_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= din;
               for (int k = 1; k < STAGES; k++) begin
                  pipe_q[k] <= pipe_q[k-1];
               end
            end
         end
         assign dout = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/asm_byte_shifter.sv
module asm_byte_shifter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         shift_in,
   output logic [W-1:0] value
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (load) begin
         value <= load_val;
      end else if (shift) begin
         value <= {value[W-2:0], shift_in};
      end
   end

endmodule

// File: rtl/asm_probe.sv
module asm_probe #(
   parameter logic [6:0] PRESENT_ADDR = 7'h10
) (
   input  logic [6:0] addr,
   output logic       found
);

   assign found = (addr == PRESENT_ADDR);

endmodule

// File: rtl/adr_serial_master.sv
module adr_serial_master
   import asm_pkg::*;
#(
   parameter int unsigned HP_W         = 12,
   parameter int unsigned LEN_W        = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter logic [6:0]  PRESENT_ADDR = 7'h10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [HP_W-1:0]  half_cycles,
   input  logic             req_valid,
   input  logic             req_read,
   input  logic [6:0]       req_addr,
   input  logic [LEN_W-1:0] req_len,
   output logic             busy,
   output logic             done,
   input  logic [7:0]       wr_data,
   input  logic             wr_valid,
   output logic             wr_ready,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   input  logic [6:0]       probe_addr,
   output logic             probe_found,
   output logic             cs_n,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso
);

   localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

   generate
      if (HP_W < 2) begin : g_bad_hp
         $error("HP_W must be at least 2");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   asm_state_e            state_q, state_d;
   logic [HP_W-1:0]       half_q, half_d, half_in, reload_val;
   logic                  dir_rd_q, dir_rd_d;
   logic                  rdm_q, rdm_d;
   logic [LEN_W-1:0]      left_q, left_d;
   logic [BIT_IDX_W-1:0]  bit_q, bit_d;
   logic                  sclk_q, sclk_d;
   logic                  mosi_q, mosi_d;
   logic                  done_q, done_d;
   logic                  rdv_q, rdv_d;
   logic [7:0]            rdd_q, rdd_d;
   logic                  restart, expired;
   logic                  sh_load, sh_shift, sh_din;
   logic [7:0]            sh_val, sh_q;
   logic                  miso_s;

   assign half_in    = (half_cycles == '0) ? HP_W'(1) : half_cycles;
   assign reload_val = (state_q == ST_IDLE) ? half_in : half_q;

   asm_phase_timer #(.HP_W(HP_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .reload  (reload_val),
      .expired (expired)
   );

   asm_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (miso),
      .dout  (miso_s)
   );

   asm_byte_shifter #(.W(BYTE_W)) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .shift    (sh_shift),
      .shift_in (sh_din),
      .value    (sh_q)
   );

   asm_probe #(.PRESENT_ADDR(PRESENT_ADDR)) i_probe (
      .addr  (probe_addr),
      .found (probe_found)
   );

   always_comb begin
      state_d  = state_q;
      half_d   = half_q;
      dir_rd_d = dir_rd_q;
      rdm_d    = rdm_q;
      left_d   = left_q;
      bit_d    = bit_q;
      sclk_d   = sclk_q;
      mosi_d   = mosi_q;
      done_d   = 1'b0;
      rdv_d    = 1'b0;
      rdd_d    = rdd_q;
      restart  = 1'b0;
      sh_load  = 1'b0;
      sh_val   = 8'h00;
      sh_shift = 1'b0;
      sh_din   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               state_d  = ST_SEL;
               restart  = 1'b1;
               half_d   = half_in;
               dir_rd_d = req_read;
               left_d   = req_len;
               rdm_d    = 1'b0;
               sh_load  = 1'b1;
               sh_val   = head_byte(req_addr, req_read);
            end
         end
         ST_SEL: begin
            if (expired) begin
               state_d = ST_LOW;
               restart = 1'b1;
               sclk_d  = 1'b0;
               mosi_d  = sh_q[7];
               bit_d   = '0;
            end
         end
         ST_FETCH: begin
            if (wr_valid) begin
               state_d = ST_LOW;
               restart = 1'b1;
               sclk_d  = 1'b0;
               mosi_d  = wr_data[7];
               bit_d   = '0;
               sh_load = 1'b1;
               sh_val  = wr_data;
            end
         end
         ST_LOW: begin
            if (expired) begin
               state_d = ST_HIGH;
               restart = 1'b1;
               sclk_d  = 1'b1;
               if (rdm_q) begin
                  sh_shift = 1'b1;
                  sh_din   = miso_s;
                  if (bit_q == LAST_BIT) begin
                     rdv_d = 1'b1;
                     rdd_d = {sh_q[6:0], miso_s};
                  end
               end
            end
         end
         ST_HIGH: begin
            if (expired) begin
               if (!rdm_q) begin
                  sh_shift = 1'b1;
               end
               if (bit_q != LAST_BIT) begin
                  state_d = ST_LOW;
                  restart = 1'b1;
                  sclk_d  = 1'b0;
                  bit_d   = bit_q + BIT_IDX_W'(1);
                  mosi_d  = rdm_q ? 1'b0 : sh_q[6];
               end else if (left_q == '0) begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
               end else begin
                  left_d = left_q - LEN_W'(1);
                  bit_d  = '0;
                  if (dir_rd_q) begin
                     rdm_d   = 1'b1;
                     state_d = ST_LOW;
                     restart = 1'b1;
                     sclk_d  = 1'b0;
                     mosi_d  = 1'b0;
                  end else begin
                     state_d = ST_FETCH;
                  end
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         half_q   <= HP_W'(1);
         dir_rd_q <= 1'b0;
         rdm_q    <= 1'b0;
         left_q   <= '0;
         bit_q    <= '0;
         sclk_q   <= 1'b1;
         mosi_q   <= 1'b0;
         done_q   <= 1'b0;
         rdv_q    <= 1'b0;
         rdd_q    <= 8'h00;
      end else begin
         state_q  <= state_d;
         half_q   <= half_d;
         dir_rd_q <= dir_rd_d;
         rdm_q    <= rdm_d;
         left_q   <= left_d;
         bit_q    <= bit_d;
         sclk_q   <= sclk_d;
         mosi_q   <= mosi_d;
         done_q   <= done_d;
         rdv_q    <= rdv_d;
         rdd_q    <= rdd_d;
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign cs_n     = (state_q == ST_IDLE);
   assign wr_ready = (state_q == ST_FETCH);
   assign sclk     = sclk_q;
   assign mosi     = mosi_q;
   assign done     = done_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;

endmodule

// File: rtl/asm_checker.sv
module asm_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic wr_ready,
   input logic rd_valid,
   input logic cs_n,
   input logic sclk,
   input logic mosi
);

   AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && sclk)); // R1

   AST_SELECT_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> sclk); // R3

   AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi) |-> $fell(sclk)); // R4

   AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R5

   AST_FETCH_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> (sclk && !cs_n)); // R6

   AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !busy && $past(busy))); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_RELEASE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> sclk); // R7

endmodule

bind adr_serial_master asm_checker i_asm_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .wr_ready (wr_ready),
   .rd_valid (rd_valid),
   .cs_n     (cs_n),
   .sclk     (sclk),
   .mosi     (mosi)
);

// File: tb/test_adr_serial_master.sv
`timescale 1ns/1ps
module test_adr_serial_master;

   localparam int HP_W  = 12;
   localparam int LEN_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [HP_W-1:0]  half_cycles = '0;
   logic             req_valid = 1'b0;
   logic             req_read = 1'b0;
   logic [6:0]       req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic             busy, done, wr_ready, rd_valid, probe_found;
   logic [7:0]       wr_data = 8'h00;
   logic             wr_valid = 1'b0;
   logic [7:0]       rd_data;
   logic [6:0]       probe_addr = '0;
   logic             cs_n, sclk, mosi;
   logic             miso = 1'b0;

   always #5 clk = ~clk;

   adr_serial_master #(.HP_W(HP_W), .LEN_W(LEN_W)) i_adr_serial_master (
      .clk(clk), .rst_n(rst_n), .half_cycles(half_cycles),
      .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr), .req_len(req_len),
      .busy(busy), .done(done),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .probe_addr(probe_addr), .probe_found(probe_found),
      .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // scoreboard queues
   logic [7:0] exp_wire_q[$];
   logic [7:0] exp_rd_q[$];
   logic [7:0] dev_tx_q[$];
   logic [7:0] wr_q[$];
   logic [7:0] pay[4];

   int  cur_h = 1;
   int  wr_delay = 0;
   int  wr_wait = 0;
   int  cyc = 0;
   int  t_mark = 0;
   int  dbit = 0;
   int  dbyte = 0;
   int  last_bytes = 0;
   int  last_low = 0;
   int  cs_falls = 0;
   bit  first_fall = 0;
   bit  dread = 0;
   bit  done_seen = 0;
   bit  prev_cs = 1'b1;
   bit  prev_sclk = 1'b1;
   logic [7:0] rxb = 8'h00;
   logic [7:0] cur_tx = 8'h00;

   // device model and monitor
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (prev_cs && !cs_n) begin
            chk(sclk == 1'b1, "R3", "clock level at select", int'(sclk), 1);
            t_mark = cyc; first_fall = 1; dbit = 0; dbyte = 0; dread = 0;
            cs_falls++;
         end
         if (!cs_n && prev_sclk && !sclk) begin
            if (first_fall)
               chk(cyc - t_mark == cur_h, "R3", "select to first fall", cyc - t_mark, cur_h);
            else if (dbit != 0)
               chk(cyc - t_mark == cur_h, "R4", "high phase length", cyc - t_mark, cur_h);
            first_fall = 0;
            t_mark = cyc;
            if (dread && dbyte >= 1) begin
               if (dbit == 0) cur_tx = (dev_tx_q.size() > 0) ? dev_tx_q.pop_front() : 8'h00;
               miso = cur_tx[7 - dbit];
            end
         end
         if (!cs_n && !prev_sclk && sclk) begin
            last_low = cyc - t_mark;
            chk(cyc - t_mark == cur_h, "R4", "low phase length", cyc - t_mark, cur_h);
            t_mark = cyc;
            rxb = {rxb[6:0], mosi};
            dbit++;
            if (dbit == 8) begin
               if (exp_wire_q.size() == 0) begin
                  chk(0, "R2", "unexpected wire byte", int'(rxb), -1);
               end else begin
                  logic [7:0] e;
                  e = exp_wire_q.pop_front();
                  chk(rxb == e, dbyte == 0 ? "R2" : "R6", "wire byte", int'(rxb), int'(e));
               end
               if (dbyte == 0) dread = rxb[0];
               dbyte++;
               dbit = 0;
            end
         end
         if (!prev_cs && cs_n) begin
            chk(dbit == 0 && sclk == 1'b1, "R7", "release on byte edge, clock high", dbit, 0);
            last_bytes = dbyte;
         end
         if (rd_valid) begin
            if (exp_rd_q.size() == 0) begin
               chk(0, "R5", "unexpected read strobe", int'(rd_data), -1);
            end else begin
               logic [7:0] e;
               e = exp_rd_q.pop_front();
               chk(rd_data == e, "R5", "read byte", int'(rd_data), int'(e));
            end
         end
         if (done) begin
            done_seen = 1;
            chk(cs_n && !busy, "R7", "done with select released and busy low", int'(busy), 0);
         end
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
   end

   // write byte source
   always @(negedge clk) begin
      if (wr_valid) begin
         wr_valid = 1'b0;
         void'(wr_q.pop_front());
         wr_wait = 0;
      end else if (wr_ready && wr_q.size() > 0) begin
         if (wr_wait >= wr_delay) begin
            chk(sclk && !cs_n, "R6", "clock parked high while fetching", int'(sclk), 1);
            wr_valid = 1'b1;
            wr_data = wr_q[0];
         end else begin
            wr_wait++;
         end
      end
   end

   task automatic xfer(input bit rd, input logic [6:0] a, input int n, input int h, input bit poke);
      int falls0;
      falls0 = cs_falls;
      exp_wire_q.push_back({a, rd});
      for (int i = 0; i < n; i++) begin
         if (rd) begin
            dev_tx_q.push_back(pay[i]);
            exp_rd_q.push_back(pay[i]);
            exp_wire_q.push_back(8'h00);
         end else begin
            wr_q.push_back(pay[i]);
            exp_wire_q.push_back(pay[i]);
         end
      end
      cur_h = (h == 0) ? 1 : h;
      done_seen = 0;
      @(negedge clk);
      half_cycles = HP_W'(h); req_read = rd; req_addr = a; req_len = LEN_W'(n); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R8", "busy after request", int'(busy), 1);
      if (poke) begin
         repeat (3) @(negedge clk);
         req_valid = 1'b1; req_addr = a ^ 7'h7f; req_read = !rd; req_len = 8'd3;
         repeat (4) @(negedge clk);
         req_valid = 1'b0;
      end
      while (!done_seen) @(negedge clk);
      chk(last_bytes == n + 1, n == 0 ? "R11" : "R7", "bytes in one select", last_bytes, n + 1);
      chk(cs_falls == falls0 + 1, "R8", "select assertions per request", cs_falls - falls0, 1);
      chk(exp_wire_q.size() == 0, "R2", "wire bytes left over", exp_wire_q.size(), 0);
      chk(exp_rd_q.size() == 0, "R5", "read bytes left over", exp_rd_q.size(), 0);
      chk(wr_q.size() == 0, "R6", "write bytes not fetched", wr_q.size(), 0);
      chk(last_low == cur_h, "R10", "measured half-period", last_low, cur_h);
      repeat (6) @(negedge clk);
      chk(cs_n == 1'b1 && busy == 1'b0, "R8", "idle after transfer", int'(cs_n), 1);
      exp_wire_q.delete(); dev_tx_q.delete();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(cs_n == 1'b1, "R1", "reset select", int'(cs_n), 1);
      chk(sclk == 1'b1, "R1", "reset clock", int'(sclk), 1);
      chk(busy == 1'b0 && wr_ready == 1'b0 && rd_valid == 1'b0, "R1", "reset flags", int'(busy), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "idle lines", int'(sclk), 1);

      probe_addr = 7'h10; #1;
      chk(probe_found == 1'b1, "R9", "probe 0x10", int'(probe_found), 1);
      for (int a = 0; a < 128; a += 17) begin
         probe_addr = 7'(a); #1;
         chk(probe_found == (a == 16), "R9", "probe other", int'(probe_found), int'(a == 16));
      end
      probe_addr = 7'h7f; #1;
      chk(probe_found == 1'b0, "R9", "probe 0x7f", int'(probe_found), 0);

      pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'h00; pay[3] = 8'h00;
      xfer(1'b0, 7'h10, 2, 3, 1'b0);            // R2 R4 R6 write
      pay[0] = 8'h5A; pay[1] = 8'hC3; pay[2] = 8'h01;
      xfer(1'b1, 7'h10, 3, 3, 1'b0);            // R5 read
      xfer(1'b0, 7'h55, 0, 4, 1'b0);            // R11 address only
      pay[0] = 8'h80;
      xfer(1'b1, 7'h2B, 1, 4, 1'b1);            // R8 requests while busy
      pay[0] = 8'hFF;
      xfer(1'b0, 7'h10, 1, 0, 1'b0);            // R10 zero acts as one
      wr_delay = 5;
      pay[0] = 8'h96; pay[1] = 8'h01; pay[2] = 8'h7E;
      xfer(1'b0, 7'h01, 3, 2, 1'b0);            // R6 host waits
      wr_delay = 0;
      pay[0] = 8'h00; pay[1] = 8'hFF;
      xfer(1'b1, 7'h7F, 2, 5, 1'b0);            // R5 extremes

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule